// File: doc/BRIEF.md
# Paged Address Translator with Access Guard

The block sits between the bus masters and main memory. It maps a 20-bit logical address onto a 20-bit physical address, using 256 pages of 4 KB. Each page has an 8-bit frame number and an 8-bit permission entry. Every bus access is checked against the permission entry of its page. The check depends on which master drives the bus and, for the CPU, on whether it runs in user or system mode. Writes that fail the check are kept from memory, but the bus cycle still completes.

Software reaches the frame and permission tables through a 12-bit I/O port space that uses even ports only. Software also reaches a violation status word, the address of the faulting access and the mode flip-flop through the same space. The first violation is held together with the low 16 bits of its address, and it raises a non-maskable interrupt request. The record is kept until software reads or clears the status word.

Top module: `page_guard`

## Requirements
- R1: `phys_addr` equals the 8-bit frame entry of page `acc_addr[19:12]` followed by `acc_addr[11:0]`. It is combinational.
- R2: A write to even port 0x200+2n loads the frame entry of page n. A write to even port 0x400+2n loads the permission entry of page n. Writes to odd ports have no effect. A read of either port returns the entry in bits 7:0, with bits 15:8 read as zero.
- R3: The master code is 0 for the CPU, 1 for the DMA/math master, and 2 or 3 for the expansion master. The permission bits are: 0 system write, 1 user write, 2 DMA write, 3 expansion write, 4 user access, 5 DMA access, 6 expansion access, 7 stack boundary. Access is denied when the master's access bit is 0. The CPU in system mode is always granted access.
- R4: An access that is granted but is a write while the master's write bit is 0 is a write violation. For the CPU, the system write bit applies in system mode and the user write bit in user mode.
- R5: `mem_we` is high only for a valid write with no access violation and no write violation. It is never high for a read.
- R6: A granted write into a page with bit 7 set flags a stack warning. The write itself is still let through.
- R7: The violation word has these bits: 0 expansion write, 1 DMA write, 2 user write, 3 stack warning, 4 bus timeout, 5 expansion access, 6 DMA access, 7 user access, 8 system write. `nmi` is high exactly while the word is nonzero.
- R8: The first violation that reaches a zero word is captured one cycle after the access, together with `acc_addr[15:0]`, which can be read at port 0x0A2. Later violations leave both unchanged until the word is cleared.
- R9: Reading port 0x0A0 returns the violation word and clears it. Writing port 0x0A0 also clears it.
- R10: A pulse on `bus_timeout` sets bit 4 of the violation word.
- R11: Writing port 0x0A4 sets user mode from bit 0 of the data, and reading it returns the mode in bit 0. `intr_ack` forces system mode and wins over a write in the same cycle.
- R12: After reset the frame entries map each page to itself, every permission entry is 0x01, the CPU is in system mode and the violation word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | I/O port write strobe |
| io_rd | input | 1 | I/O port read strobe |
| io_addr | input | 12 | I/O port address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data (combinational) |
| acc_valid | input | 1 | Bus access in progress |
| acc_write | input | 1 | Access is a write |
| acc_master | input | 2 | Master code: 0 CPU, 1 DMA/math, 2 or 3 expansion |
| acc_addr | input | 20 | Logical address |
| bus_timeout | input | 1 | Bus access timeout pulse |
| intr_ack | input | 1 | Interrupt acknowledge, returns the CPU to system mode |
| phys_addr | output | 20 | Translated address |
| mem_we | output | 1 | Write enable forwarded to memory |
| nmi | output | 1 | Non-maskable interrupt request |
| user_mode | output | 1 | Current CPU mode, 1 for user |

## Verification
The bench fills both tables with random entries and then makes random accesses over all four master codes, both directions and both CPU modes. Comparing the translated address with the expected one shows whether the frame lookup uses the right page. Comparing the write enable and the violation word with the expected values shows whether access bits, write bits and the stack flag are chosen for the right master. Directed cases cover further corners:
- the reset contents of both tables;
- an odd-port write, which must change nothing;
- two violations back to back, where only the first is kept;
- a clear by writing the status port;
- a bus timeout;
- an interrupt acknowledge that arrives together with a mode write.

// File: rtl/page_guard.sv
module page_guard #(
  parameter int PAGE_BITS = 8,
  parameter int OFFS_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [11:0] io_addr,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_master,
  input  logic [19:0] acc_addr,
  input  logic        bus_timeout,
  input  logic        intr_ack,
  output logic [19:0] phys_addr,
  output logic        mem_we,
  output logic        nmi,
  output logic        user_mode
);
  localparam int PAGES = 1 << PAGE_BITS;
  localparam logic [11:0] STAT_PORT = 12'h0A0;
  localparam logic [11:0] ADDR_PORT = 12'h0A2;
  localparam logic [11:0] MODE_PORT = 12'h0A4;

  logic [7:0]  frame_q [PAGES];
  logic [7:0]  perm_q  [PAGES];
  logic [8:0]  viol_q;
  logic [15:0] fault_q;
  logic        mode_q;

  logic [PAGE_BITS-1:0] io_idx, pg;
  logic frame_sel, perm_sel, stat_clr;
  logic [7:0] pc;
  logic is_exp, is_dma, is_usr, deny, wr_ok, wr_bad;
  logic [8:0] new_bits;

  assign io_idx    = io_addr[PAGE_BITS:1];
  assign frame_sel = io_addr[11:9] == 3'b001 && !io_addr[0];
  assign perm_sel  = io_addr[11:9] == 3'b010 && !io_addr[0];
  assign stat_clr  = (io_wr || io_rd) && io_addr == STAT_PORT;

  assign pg        = acc_addr[19:OFFS_BITS];
  assign pc        = perm_q[pg];
  assign phys_addr = {frame_q[pg], acc_addr[OFFS_BITS-1:0]};

  assign is_exp = acc_master[1];
  assign is_dma = acc_master == 2'd1;
  assign is_usr = acc_master == 2'd0 && mode_q;
  assign deny   = is_exp ? !pc[6] : is_dma ? !pc[5] : is_usr ? !pc[4] : 1'b0;
  assign wr_ok  = is_exp ? pc[3] : is_dma ? pc[2] : is_usr ? pc[1] : pc[0];
  assign wr_bad = acc_valid && acc_write && !deny && !wr_ok;
  assign mem_we = acc_valid && acc_write && !deny && wr_ok;

  always_comb begin
    new_bits = '0;
    if (acc_valid && deny) begin
      if (is_exp)      new_bits[5] = 1'b1;
      else if (is_dma) new_bits[6] = 1'b1;
      else             new_bits[7] = 1'b1;
    end
    if (wr_bad) begin
      if (is_exp)      new_bits[0] = 1'b1;
      else if (is_dma) new_bits[1] = 1'b1;
      else if (is_usr) new_bits[2] = 1'b1;
      else             new_bits[8] = 1'b1;
    end
    if (acc_valid && acc_write && !deny && pc[7]) new_bits[3] = 1'b1;
    if (bus_timeout) new_bits[4] = 1'b1;
  end

  always_comb begin
    io_rdata = '0;
    if (frame_sel)              io_rdata[7:0] = frame_q[io_idx];
    else if (perm_sel)          io_rdata[7:0] = perm_q[io_idx];
    else if (io_addr == STAT_PORT) io_rdata[8:0] = viol_q;
    else if (io_addr == ADDR_PORT) io_rdata = fault_q;
    else if (io_addr == MODE_PORT) io_rdata[0] = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) begin
        frame_q[i] <= 8'(i);
        perm_q[i]  <= 8'h01;
      end
    end else if (io_wr) begin
      if (frame_sel) frame_q[io_idx] <= io_wdata[7:0];
      if (perm_sel)  perm_q[io_idx]  <= io_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= '0;
      fault_q <= '0;
    end else if (stat_clr) begin
      viol_q <= new_bits;
      if (|new_bits) fault_q <= acc_addr[15:0];
    end else if (viol_q == '0 && |new_bits) begin
      viol_q  <= new_bits;
      fault_q <= acc_addr[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mode_q <= 1'b0;
    else if (intr_ack)                       mode_q <= 1'b0;
    else if (io_wr && io_addr == MODE_PORT)  mode_q <= io_wdata[0];
  end

  assign nmi       = |viol_q;
  assign user_mode = mode_q;

  // R8
  hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !stat_clr) |=> $stable(viol_q) && $stable(fault_q));
  // R11
  ack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |=> !user_mode);
  // R5
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |-> !mem_we);
  // R7
  nmi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(acc_valid || bus_timeout));
  // R3
  exp_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_exp && !pc[6]) |-> !mem_we);
endmodule

// File: tb/test_page_guard.sv
module test_page_guard;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0;
  logic [11:0] io_addr = 0;
  logic [15:0] io_wdata = 0, io_rdata;
  logic acc_valid = 0, acc_write = 0;
  logic [1:0] acc_master = 0;
  logic [19:0] acc_addr = 0, phys_addr;
  logic bus_timeout = 0, intr_ack = 0;
  logic mem_we, nmi, user_mode;

  int checks = 0, errors = 0;
  logic [7:0] m_frame [256];
  logic [7:0] m_perm  [256];
  logic m_user = 0;

  always #(CLK_P/2) clk = ~clk;

  page_guard i_page_guard (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [11:0] a, logic [15:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [11:0] a, output logic [15:0] d);
    @(negedge clk); io_rd = 1; io_addr = a; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  function automatic logic [8:0] exp_bits(logic [7:0] p, logic [1:0] m, logic w, logic u);
    logic exp_m = m[1], dma = (m == 2'd1), usr = (m == 2'd0) && u;
    logic dn = exp_m ? !p[6] : dma ? !p[5] : usr ? !p[4] : 1'b0;
    logic wok = exp_m ? p[3] : dma ? p[2] : usr ? p[1] : p[0];
    logic [8:0] b = '0;
    if (dn) b[exp_m ? 5 : dma ? 6 : 7] = 1'b1;
    else if (w) begin
      if (!wok) b[exp_m ? 0 : dma ? 1 : usr ? 2 : 8] = 1'b1;
      if (p[7]) b[3] = 1'b1;
    end
    return b;
  endfunction

  function automatic logic exp_we(logic [7:0] p, logic [1:0] m, logic w, logic u);
    logic [8:0] b = exp_bits(p, m, w, u);
    return w && b[7:5] == 0 && b[2:0] == 0 && !b[8];
  endfunction

  task automatic access(logic [19:0] a, logic [1:0] m, logic w);
    logic [15:0] d;
    logic [8:0] eb;
    logic [7:0] p = m_perm[a[19:12]];
    eb = exp_bits(p, m, w, m_user);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_master = m; acc_write = w;
    #1;
    chk("R1 phys", 32'(phys_addr), 32'({m_frame[a[19:12]], a[11:0]}));
    chk("R3 R4 R5 R6 mem_we", 32'(mem_we), 32'(exp_we(p, m, w, m_user)));
    @(negedge clk); acc_valid = 0; acc_write = 0;
    chk("R7 nmi", 32'(nmi), 32'(eb != 0));
    io_read(12'h0A0, d);
    chk("R7 R9 status", 32'(d), 32'(eb));
    if (eb != 0) begin
      io_read(12'h0A2, d);
      chk("R8 fault addr", 32'(d), 32'(a[15:0]));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd5150));
    for (int i = 0; i < 256; i++) begin m_frame[i] = 8'(i); m_perm[i] = 8'h01; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    io_read(12'h200 + 12'd2 * 12'd77, d); chk("R12 frame reset", 32'(d), 32'h4D);
    io_read(12'h400 + 12'd2 * 12'd200, d); chk("R12 perm reset", 32'(d), 32'h01);
    chk("R12 mode", 32'(user_mode), 0);
    chk("R12 nmi", 32'(nmi), 0);
    // R2 fill tables randomly
    for (int i = 0; i < 256; i++) begin
      m_frame[i] = 8'($urandom);
      m_perm[i]  = 8'($urandom);
      io_write(12'h200 + 12'(2 * i), {8'($urandom), m_frame[i]});
      io_write(12'h400 + 12'(2 * i), {8'($urandom), m_perm[i]});
    end
    io_read(12'h200 + 12'd6, d); chk("R2 frame rd", 32'(d), 32'(m_frame[3]));
    io_read(12'h400 + 12'd510, d); chk("R2 perm rd hi zero", 32'(d), 32'(m_perm[255]));
    // R2 odd port ignored
    io_write(12'h207, 16'h00FF);
    io_read(12'h206, d); chk("R2 odd port", 32'(d), 32'(m_frame[3]));
    io_write(12'h409, 16'h00AA);
    io_read(12'h408, d); chk("R2 odd port perm", 32'(d), 32'(m_perm[4]));
    // random accesses with mode changes
    for (int k = 0; k < 400; k++) begin
      if (k % 17 == 0) begin
        m_user = 1'($urandom);
        io_write(12'h0A4, {15'd0, m_user});
        chk("R11 mode", 32'(user_mode), 32'(m_user));
      end
      access(20'($urandom), 2'($urandom), 1'($urandom));
    end
    // R6 stack page write allowed and flagged
    m_perm[9] = 8'h81; io_write(12'h412, 16'h0081);
    m_user = 0; io_write(12'h0A4, 16'h0);
    access(20'h09ABC, 2'd0, 1'b1);
    // R3 system CPU denied write when system-write bit clear
    m_perm[10] = 8'h00; io_write(12'h414, 16'h0000);
    access(20'h0A123, 2'd0, 1'b1);
    access(20'h0A124, 2'd0, 1'b0);
    // R3 expansion master with code 3
    access(20'h0A125, 2'd3, 1'b0);
    // R8 first held: two violations back to back
    @(negedge clk); acc_valid = 1; acc_master = 2'd1; acc_write = 0; acc_addr = 20'h0A111;
    @(negedge clk); acc_master = 2'd2; acc_addr = 20'h0A222;
    @(negedge clk); acc_valid = 0;
    io_read(12'h0A2, d); chk("R8 first addr held", 32'(d), 32'hA111);
    io_read(12'h0A0, d); chk("R8 first bits held", 32'(d), 32'h040);
    chk("R9 cleared by read", 32'(nmi), 0);
    // R9 clear by write
    @(negedge clk); bus_timeout = 1;
    @(negedge clk); bus_timeout = 0;
    chk("R10 timeout nmi", 32'(nmi), 1);
    io_write(12'h0A0, 16'h0);
    chk("R9 cleared by write", 32'(nmi), 0);
    // R10 timeout bit
    @(negedge clk); bus_timeout = 1;
    @(negedge clk); bus_timeout = 0;
    io_read(12'h0A0, d); chk("R10 timeout bit", 32'(d), 32'h010);
    // R11 intr_ack wins over mode write
    io_write(12'h0A4, 16'h1);
    chk("R11 set user", 32'(user_mode), 1);
    @(negedge clk); io_wr = 1; io_addr = 12'h0A4; io_wdata = 16'h1; intr_ack = 1;
    @(negedge clk); io_wr = 0; intr_ack = 0;
    chk("R11 ack priority", 32'(user_mode), 0);
    io_read(12'h0A4, d); chk("R11 mode read", 32'(d), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule